// File: doc/BRIEF.md
# Multistage Processor-to-Memory Request Network

This block joins N processor request ports to N memory-module ports through a network of log2(N) switching stages. Each stage holds N/2 two-input, two-output switching elements, so the whole network has (N/2)·log2(N) elements. A single-level crossbar would need (N/2)^2 elements of the same size. The price is path length. Every request crosses one element in each stage, so it makes log2(N) hops where a crossbar makes one.

Each element looks at one address bit to pick its output. Stage k uses bit k of the module index, starting with bit 0 in the first stage. An inverse-shuffle wiring between stages rotates the line index right by one position. This puts each request at the module whose index equals the low log2(N) bits of its address. Every element output is a register, so an unobstructed request arrives after exactly log2(N) cycles.

All ports use valid/ready handshakes that carry an address and a data word. When two requests inside an element want the same output, one of them sees ready low and waits. The element then grants the other input the next time the same conflict occurs. Nothing is dropped. Requests from one processor to one module arrive in the order they were issued.

Top module: `mem_net`

## Requirements
- R1: During reset and right after it, with no requests presented, every `mem_valid` bit is 0 and every `cpu_ready` bit is 1.
- R2: Every request accepted on a processor port (`cpu_valid` and `cpu_ready` both 1 at a clock edge) is delivered exactly once on a memory port, with its address and data unchanged.
- R3: A request is delivered on the memory port whose index equals bits [log2(N)-1:0] of its address. The element in stage k steers on address bit k: a 0 selects its lower output and a 1 selects its upper output.
- R4: A request that meets no conflict and no stall appears on `mem_valid` exactly log2(N) clock cycles after the edge that accepted it.
- R5: Processor ports 2j and 2j+1 share a first-stage element. When both present requests with the same value of address bit 0, exactly one of them sees `cpu_ready` high. While both contend continuously, they are granted alternately.
- R6: While `mem_ready[m]` is 0, a pending `mem_valid[m]` stays 1 and `mem_addr[m]` and `mem_data[m]` stay unchanged. When the memory ports stay stalled long enough, the processor ports see `cpu_ready` low.
- R7: Requests from one processor to one memory module arrive in issue order.
- R8: A single processor streaming to one module, with that module always ready and no other traffic, sees `cpu_ready` high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_valid | input | N | Request valid, one bit per processor port |
| cpu_ready | output | N | Request accepted when high together with valid |
| cpu_addr | input | N x AW | Request address per processor; the low log2(N) bits select the module |
| cpu_data | input | N x DW | Request data per processor |
| mem_valid | output | N | Request present, one bit per memory port |
| mem_ready | input | N | Memory module takes the request when high |
| mem_addr | output | N x AW | Delivered address per memory port |
| mem_data | output | N x DW | Delivered data per memory port |

## Verification
Single requests sent one processor at a time isolate the routing decision and the fixed log2(N)-cycle latency from any arbitration effect. Two processors that share a first-stage element and target the same output show the single-winner rule and the alternation between contenders. A lone streaming source separates full-rate throughput from stalls. A full stall of every memory port shows that back-pressure reaches the processors without losing data. All-pairs traffic and random traffic under random memory readiness check exactly-once delivery and per-pair ordering against per-processor, per-module queues that a model in the testbench keeps on every clock.

// File: rtl/mnet_pkg.sv
package mnet_pkg;

  // Inverse shuffle: rotate a line index of the given width right by one bit.
  function automatic int unshuffle(input int q, input int bits);
    return (q >> 1) | ((q & 1) << (bits - 1));
  endfunction

endpackage

// File: rtl/mnet_elem.sv
module mnet_elem #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int BIT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          in_v,
  output logic [1:0]          in_rdy,
  input  logic [1:0][AW-1:0]  in_addr,
  input  logic [1:0][DW-1:0]  in_data,
  output logic [1:0]          out_v,
  input  logic [1:0]          out_rdy,
  output logic [1:0][AW-1:0]  out_addr,
  output logic [1:0][DW-1:0]  out_data
);

  logic [1:0] sel, load, conf, g0, g1, pri_q, pri_d, v_d;

  // Next-state: steering, conflict detection and round-robin grant
  always_comb begin
    sel = {in_addr[1][BIT], in_addr[0][BIT]};
    for (int o = 0; o < 2; o++) begin
      load[o]  = !out_v[o] || out_rdy[o];
      conf[o]  = in_v[0] && in_v[1] && (sel[0] == o[0]) && (sel[1] == o[0]);
      g0[o]    = in_v[0] && (sel[0] == o[0]) && load[o] && !(conf[o] && pri_q[o]);
      g1[o]    = in_v[1] && (sel[1] == o[0]) && load[o] && !(conf[o] && !pri_q[o]);
      v_d[o]   = load[o] ? (g0[o] || g1[o]) : out_v[o];
      pri_d[o] = (conf[o] && load[o]) ? !pri_q[o] : pri_q[o];
    end
    in_rdy[0] = load[sel[0]] && !(conf[sel[0]] && pri_q[sel[0]]);
    in_rdy[1] = load[sel[1]] && !(conf[sel[1]] && !pri_q[sel[1]]);
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= '0;
      pri_q <= '0;
    end else begin
      out_v <= v_d;
      pri_q <= pri_d;
    end
  end

  // Payload registers, loaded only on a grant
  always_ff @(posedge clk) begin
    for (int o = 0; o < 2; o++) begin
      if (g0[o] || g1[o]) begin
        out_addr[o] <= g0[o] ? in_addr[0] : in_addr[1];
        out_data[o] <= g0[o] ? in_data[0] : in_data[1];
      end
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v == 2'b11 && sel[0] == sel[1]) |-> (in_rdy != 2'b11)); // R5

  for (genvar o = 0; o < 2; o++) begin : g_chk
    AST_ROUTE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_v[o] |-> (out_addr[o][BIT] == 1'(o))); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_v[o] && !out_rdy[o]) |=> (out_v[o] && $stable(out_addr[o]) && $stable(out_data[o]))); // R6
  end

endmodule

// File: rtl/mnet_stage.sv
module mnet_stage #(
  parameter int N   = 8,
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int BIT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        in_v,
  output logic [N-1:0]        in_rdy,
  input  logic [N-1:0][AW-1:0] in_addr,
  input  logic [N-1:0][DW-1:0] in_data,
  output logic [N-1:0]        out_v,
  input  logic [N-1:0]        out_rdy,
  output logic [N-1:0][AW-1:0] out_addr,
  output logic [N-1:0][DW-1:0] out_data
);

  localparam int S = $clog2(N);
  localparam int E = N / 2;

  logic [N-1:0]         ev, er;
  logic [N-1:0][AW-1:0] ea;
  logic [N-1:0][DW-1:0] ed;

  for (genvar j = 0; j < E; j++) begin : g_el
    mnet_elem #(.AW(AW), .DW(DW), .BIT(BIT)) u_el (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_v     (in_v[2*j+1:2*j]),
      .in_rdy   (in_rdy[2*j+1:2*j]),
      .in_addr  (in_addr[2*j+1:2*j]),
      .in_data  (in_data[2*j+1:2*j]),
      .out_v    (ev[2*j+1:2*j]),
      .out_rdy  (er[2*j+1:2*j]),
      .out_addr (ea[2*j+1:2*j]),
      .out_data (ed[2*j+1:2*j])
    );
  end

  // Inverse-shuffle wiring toward the next stage
  for (genvar q = 0; q < N; q++) begin : g_wire
    localparam int D = mnet_pkg::unshuffle(q, S);
    assign out_v[D]    = ev[q];
    assign out_addr[D] = ea[q];
    assign out_data[D] = ed[q];
    assign er[q]       = out_rdy[D];
  end

endmodule

// File: rtl/mem_net.sv
module mem_net #(
  parameter int N  = 8,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         cpu_valid,
  output logic [N-1:0]         cpu_ready,
  input  logic [N-1:0][AW-1:0] cpu_addr,
  input  logic [N-1:0][DW-1:0] cpu_data,
  output logic [N-1:0]         mem_valid,
  input  logic [N-1:0]         mem_ready,
  output logic [N-1:0][AW-1:0] mem_addr,
  output logic [N-1:0][DW-1:0] mem_data
);

  localparam int S = $clog2(N);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  logic [N-1:0]         sv [0:S];
  logic [N-1:0]         sr [0:S];
  logic [N-1:0][AW-1:0] sa [0:S];
  logic [N-1:0][DW-1:0] sd [0:S];

  assign sv[0]     = cpu_valid;
  assign sa[0]     = cpu_addr;
  assign sd[0]     = cpu_data;
  assign cpu_ready = sr[0];
  assign mem_valid = sv[S];
  assign mem_addr  = sa[S];
  assign mem_data  = sd[S];
  assign sr[S]     = mem_ready;

  for (genvar s = 0; s < S; s++) begin : g_stage
    mnet_stage #(.N(N), .AW(AW), .DW(DW), .BIT(s)) u_stage (
      .clk      (clk),
      .rst_n    (rst_i),
      .in_v     (sv[s]),
      .in_rdy   (sr[s]),
      .in_addr  (sa[s]),
      .in_data  (sd[s]),
      .out_v    (sv[s+1]),
      .out_rdy  (sr[s+1]),
      .out_addr (sa[s+1]),
      .out_data (sd[s+1])
    );
  end

  for (genvar m = 0; m < N; m++) begin : g_port_chk
    AST_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_i)
      mem_valid[m] |-> (mem_addr[m][S-1:0] == S'(m))); // R3
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
      (mem_valid[m] && !mem_ready[m]) |=> mem_valid[m]); // R6
  end

endmodule

// File: tb/sim_mem_net.sv
module sim_mem_net;

  localparam int N  = 8;
  localparam int S  = 3;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int EW = AW + DW;

  logic                 clk, rst_n;
  logic [N-1:0]         cpu_valid, cpu_ready, mem_valid, mem_ready;
  logic [N-1:0][AW-1:0] cpu_addr, mem_addr;
  logic [N-1:0][DW-1:0] cpu_data, mem_data;

  mem_net #(.N(N), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int seq [N];
  logic [EW-1:0] sq [N][$];
  logic [EW-1:0] eq [N*N][$];
  int            et [N*N][$];
  bit lat_chk = 0, conf_chk = 0, alt_chk = 0, stream_chk = 0, saw_block = 0;
  int mr_mode = 0;
  int last_src = -1;
  logic [N-1:0]         pv = '0, pr = '0;
  logic [N-1:0][AW-1:0] pa;
  logic [N-1:0][DW-1:0] pd;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int c, input int dest);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    a = AW'($urandom);
    a[S-1:0] = S'(dest);
    d = {4'(c), 12'(seq[c])};
    seq[c]++;
    sq[c].push_back({a, d});
  endtask

  function automatic int pending();
    int n = 0;
    for (int i = 0; i < N; i++) n += sq[i].size();
    for (int i = 0; i < N*N; i++) n += eq[i].size();
    return n;
  endfunction

  task automatic step();
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      if (sq[c].size() > 0) begin
        cpu_valid[c] = 1'b1;
        {cpu_addr[c], cpu_data[c]} = sq[c][0];
      end else begin
        cpu_valid[c] = 1'b0;
        cpu_addr[c]  = '0;
        cpu_data[c]  = '0;
      end
    end
    for (int m = 0; m < N; m++)
      mem_ready[m] = (mr_mode == 0) ? 1'b1 : (mr_mode == 1) ? 1'b0 : (($urandom % 4) != 0);
    #3;
    if (conf_chk && cpu_valid[0] && cpu_valid[1]) begin
      chk(cpu_ready[0] ^ cpu_ready[1], "R5", "single winner among contenders", cpu_ready[1:0], 1);
      conf_chk = 0;
    end
    if (stream_chk && cpu_valid[2])
      chk(cpu_ready[2], "R8", "streaming source ready", cpu_ready[2], 1);
    if ((cpu_valid & ~cpu_ready) != '0) saw_block = 1;
    for (int m = 0; m < N; m++)
      if (pv[m] && !pr[m])
        chk(mem_valid[m] && mem_addr[m] == pa[m] && mem_data[m] == pd[m], "R6",
            "stalled output held", mem_data[m], pd[m]);
    for (int m = 0; m < N; m++) begin
      if (mem_valid[m] && mem_ready[m]) begin
        int c;
        c = int'(mem_data[m][DW-1:DW-4]);
        chk(mem_addr[m][S-1:0] == S'(m), "R3", "arrival port", mem_addr[m][S-1:0], m);
        if (c >= N) chk(0, "R2", "source id out of range", c, 0);
        else begin
          int qi;
          qi = m * N + c;
          if (eq[qi].size() == 0) chk(0, "R2", "unexpected extra delivery", mem_data[m], 0);
          else begin
            chk(eq[qi][0] == {mem_addr[m], mem_data[m]}, "R7", "in-order payload",
                mem_data[m], eq[qi][0][DW-1:0]);
            if (lat_chk) chk(cyc - et[qi][0] == S, "R4", "latency", cyc - et[qi][0], S);
            void'(eq[qi].pop_front());
            void'(et[qi].pop_front());
          end
          if (alt_chk && m == 0) begin
            if (last_src >= 0) chk(c != last_src, "R5", "alternating grant", c, 1 - last_src);
            last_src = c;
          end
        end
      end
    end
    for (int c = 0; c < N; c++) begin
      if (cpu_valid[c] && cpu_ready[c]) begin
        int qi;
        qi = int'(cpu_addr[c][S-1:0]) * N + c;
        eq[qi].push_back(sq[c][0]);
        et[qi].push_back(cyc);
        void'(sq[c].pop_front());
      end
    end
    pv = mem_valid; pr = mem_ready; pa = mem_addr; pd = mem_data;
    @(posedge clk);
    cyc++;
  endtask

  task automatic drain();
    int n = 0;
    while (pending() > 0 && n < 4000) begin
      step();
      n++;
    end
    chk(pending() == 0, "R2", "network drained", pending(), 0);
  endtask

  initial begin
    for (int c = 0; c < N; c++) seq[c] = 0;
    rst_n = 1'b0;
    cpu_valid = '0; cpu_addr = '0; cpu_data = '0; mem_ready = '1;
    repeat (3) step();
    chk(mem_valid == '0, "R1", "no output during reset", mem_valid, 0);
    rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk); #3;
    chk(mem_valid == '0, "R1", "no output after reset", mem_valid, 0);
    chk(cpu_ready == '1, "R1", "all inputs ready after reset", cpu_ready, 255);
    @(posedge clk);

    // R4: isolated requests, one processor at a time
    lat_chk = 1;
    for (int c = 0; c < N; c++) begin
      push(c, (c * 3 + 1) % N);
      drain();
    end
    lat_chk = 0;

    // R5: contenders in one first-stage element, same bit 0
    push(0, 0);
    push(1, 2);
    conf_chk = 1;
    drain();
    chk(!conf_chk, "R5", "contention observed", conf_chk, 0);

    // R5: sustained contention alternates
    last_src = -1;
    alt_chk = 1;
    for (int k = 0; k < 4; k++) begin
      push(0, 0);
      push(1, 0);
    end
    drain();
    alt_chk = 0;

    // R8: single source streaming
    stream_chk = 1;
    repeat (6) push(2, 5);
    drain();
    stream_chk = 0;

    // R6: every memory port stalled
    mr_mode = 1;
    saw_block = 0;
    for (int c = 0; c < N; c++) repeat (4) push(c, $urandom % N);
    repeat (12) step();
    chk(saw_block, "R6", "back-pressure reached processors", saw_block, 1);
    mr_mode = 0;
    drain();

    // R2, R3: every processor to every module
    mr_mode = 2;
    for (int c = 0; c < N; c++)
      for (int k = 0; k < N; k++) push(c, (c + k) % N);
    drain();

    // R2, R7: random traffic
    for (int k = 0; k < 40; k++)
      for (int c = 0; c < N; c++) push(c, $urandom % N);
    drain();

    for (int i = 0; i < N*N; i++)
      chk(eq[i].size() == 0, "R2", "each request delivered once", eq[i].size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule